// File: doc/BRIEF.md
# Dual-Order Burst Offset Generator

This block produces the two least significant bits of a word address for a four-beat burst. When an already qualified address strobe arrives, it captures the full incoming address. The upper bits go into a holding register. The two low bits become the starting offset of the burst.

Each following cycle in which the active-low advance input is asserted moves the offset to the next beat. When advance is not asserted, the offset stays where it is. After four advances the offset is back at the starting value.

A static order input chooses one of two beat orders:
- Linear order: the offset counts up from the start, modulo four.
- Interleaved order: the offset is the start XORed with a beat index running 0, 1, 2, 3.

A new accepted strobe always restarts the burst from the new address, even partway through a burst. In the cycle of that strobe the advance input has no effect.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) makes `offset_out` 2'b00 and `base_out` all zeros from the next edge.
- R2: When `load_ok` is high at a rising edge, after that edge `offset_out` equals `addr_in[1:0]` and `base_out` equals `addr_in[ADDR_W-1:2]`.
- R3: With `order_sel` = 0 (linear), each edge with `load_ok` low and `adv_n` low sets the offset to the previous offset plus 1, modulo 4 (start 01 gives 01, 10, 11, 00).
- R4: With `order_sel` = 1 (interleaved), the k-th offset after a load is the start XOR k, for k = 0..3 (start 10 gives 10, 11, 00, 01).
- R5: An edge with `load_ok` low and `adv_n` high leaves both `offset_out` and `base_out` unchanged, whatever `addr_in` holds.
- R6: After four advances without an intervening load, the offset has returned to the start value, in either order.
- R7: A load takes priority over advance: with `load_ok` high and `adv_n` low, the offset after the edge is `addr_in[1:0]`, not the next beat.
- R8: `base_out` changes only on a load or a reset; advancing never alters it.
- R9: A load in the middle of a burst restarts the sequence from the new start, with the beat count back at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load_ok | input | 1 | Qualified address strobe: capture `addr_in` this edge |
| adv_n | input | 1 | Advance to the next beat, active low |
| order_sel | input | 1 | Beat order: 0 linear, 1 interleaved (static) |
| addr_in | input | ADDR_W | Incoming address |
| base_out | output | ADDR_W-2 | Registered upper address bits |
| offset_out | output | 2 | Current burst offset |

## Verification
The assertions assume that `order_sel` is treated as a strap. The interleaved step property in particular relies on the order not changing inside a burst. The stimulus therefore changes `order_sel` only during reset or in the same cycle as a load, so every burst runs entirely in one order. The checks also assume that `load_ok` already includes any chip-select qualification. The bench drives `load_ok` directly and exercises loads that coincide with advance, and loads that arrive mid-burst.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int unsigned OFS_W = 2;
  typedef logic [OFS_W-1:0] ofs_t;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  // Offset presented for beat idx of a burst that started at start.
  function automatic ofs_t map_offset(input ofs_t start, input ofs_t idx,
                                      input order_e ord);
    ofs_t r;
    if (ord == ORD_XOR) r = start ^ idx;
    else                r = start + idx;
    return r;
  endfunction

  // Beat index after one advance; wraps naturally at four beats.
  function automatic ofs_t bump(input ofs_t idx);
    return idx + ofs_t'(1);
  endfunction
endpackage

// File: rtl/bag_base_reg.sv
module bag_base_reg #(
  parameter int unsigned UW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_ev,
  input  logic [UW-1:0] base_in,
  output logic [UW-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (rst)          base_q <= '0;
    else if (load_ev) base_q <= base_in;
  end
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr
  import burst_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_ev,
  input  logic step_ev,
  input  ofs_t load_ofs,
  output ofs_t start_q,
  output ofs_t idx_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      idx_q   <= '0;
    end else if (load_ev) begin
      start_q <= load_ofs;
      idx_q   <= '0;
    end else if (step_ev) begin
      idx_q   <= bump(idx_q);
    end
  end
endmodule

// File: rtl/bag_offset_map.sv
module bag_offset_map
  import burst_pkg::*;
(
  input  ofs_t   start,
  input  ofs_t   idx,
  input  order_e ord,
  output ofs_t   ofs
);
  always_comb ofs = map_offset(start, idx, ord);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_ok,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-3:0] base_out,
  output logic [1:0]        offset_out
);
  localparam int unsigned UW = ADDR_W - OFS_W;

  // Named events, brought out for the checker.
  logic   load_ev;
  logic   step_ev;
  logic   hold_ev;
  order_e ord;
  ofs_t   start_q;
  ofs_t   idx_q;
  ofs_t   ofs_c;

  assign load_ev = load_ok;
  assign step_ev = !load_ok && !adv_n;
  assign hold_ev = !load_ok && adv_n;
  assign ord     = order_e'(order_sel);

  bag_base_reg #(.UW(UW)) u_base (
    .clk     (clk),
    .rst     (rst),
    .load_ev (load_ev),
    .base_in (addr_in[ADDR_W-1:OFS_W]),
    .base_q  (base_out)
  );

  bag_beat_ctr u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load_ev  (load_ev),
    .step_ev  (step_ev),
    .load_ofs (addr_in[OFS_W-1:0]),
    .start_q  (start_q),
    .idx_q    (idx_q)
  );

  bag_offset_map u_map (
    .start (start_q),
    .idx   (idx_q),
    .ord   (ord),
    .ofs   (ofs_c)
  );

  assign offset_out = ofs_c;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int unsigned ADDR_W = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              load_ok,
  input logic              adv_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-3:0] base_out,
  input logic [1:0]        offset_out,
  input logic              step_ev,
  input logic              hold_ev
);
  logic prev_rst = 1'b0;
  always_ff @(posedge clk) prev_rst <= rst;

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    prev_rst |-> (offset_out == 2'b00 && base_out == '0));

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (rst)
    load_ok |=> (offset_out == $past(addr_in[1:0]) &&
                 base_out == $past(addr_in[ADDR_W-1:2])));

  // R7
  load_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (load_ok && !adv_n) |=> offset_out == $past(addr_in[1:0]));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step_ev && !order_sel) |=> offset_out == $past(offset_out) + 2'd1);

  // R4
  xor_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step_ev && order_sel) |=> offset_out[0] != $past(offset_out[0]));

  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    hold_ev |=> ($stable(offset_out) && $stable(base_out)));

  // R8
  base_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !load_ok |=> $stable(base_out));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load_ok    (load_ok),
  .adv_n      (adv_n),
  .order_sel  (order_sel),
  .addr_in    (addr_in),
  .base_out   (base_out),
  .offset_out (offset_out),
  .step_ev    (step_ev),
  .hold_ev    (hold_ev)
);

// File: tb/tb_burst_addr_gen.sv
`timescale 1ns/1ps
module tb_burst_addr_gen;
  localparam int unsigned AW = 15;

  typedef struct {
    logic [AW-3:0] base;
    logic [1:0]    ofs;
    string         tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_ok = 1'b0;
  logic          adv_n = 1'b1;
  logic          order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-3:0] base_out;
  logic [1:0]    offset_out;

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  exp_t q[$];

  // Reference state, kept in the bench's own terms.
  logic [AW-3:0] m_base = '0;
  logic [1:0]    m_ofs = '0;
  logic [1:0]    m_start = '0;
  int            m_beat = 0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .load_ok(load_ok), .adv_n(adv_n),
    .order_sel(order_sel), .addr_in(addr_in),
    .base_out(base_out), .offset_out(offset_out)
  );

  task automatic cyc(input logic r, input logic ld, input logic adv,
                     input logic ord, input logic [AW-1:0] a, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; load_ok = ld; adv_n = adv; order_sel = ord; addr_in = a;
    if (r) begin
      m_base = '0; m_ofs = '0; m_start = '0; m_beat = 0;
    end else if (ld) begin
      m_base = a[AW-1:2]; m_start = a[1:0]; m_ofs = a[1:0]; m_beat = 0;
    end else if (!adv) begin
      m_beat = (m_beat + 1) % 4;
      if (ord) m_ofs = m_start ^ 2'(m_beat);
      else     m_ofs = 2'((int'(m_ofs) + 1) % 4);
    end
    e.base = m_base; e.ofs = m_ofs; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: outputs settle after the edge; sample 1 ns later.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        vectors++;
        if (offset_out !== e.ofs || base_out !== e.base) begin
          fails++;
          $display("FAIL %s offset=%b/exp %b base=%h/exp %h",
                   e.tag, offset_out, e.ofs, base_out, e.base);
        end
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    cyc(1, 0, 1, 0, 15'h7FFF, "R1 reset");
    cyc(1, 1, 0, 1, 15'h1234, "R1 reset over load");
    // Linear burst from 01, wrapping.
    cyc(0, 1, 1, 0, 15'h1235, "R2 load linear");
    cyc(0, 0, 0, 0, 15'h0000, "R3 linear beat2 R8");
    cyc(0, 0, 0, 0, 15'h7FFC, "R3 linear beat3 R8");
    cyc(0, 0, 0, 0, 15'h0000, "R3 linear beat4");
    cyc(0, 0, 0, 0, 15'h0000, "R6 linear wrap");
    // Hold with changing address.
    cyc(0, 0, 1, 0, 15'h5A5A, "R5 hold");
    cyc(0, 0, 1, 0, 15'h2222, "R5 hold");
    // Interleaved burst from 10.
    cyc(0, 1, 1, 1, 15'h6AAA, "R2 load interleaved");
    cyc(0, 0, 0, 1, 15'h0000, "R4 xor beat2");
    cyc(0, 0, 1, 1, 15'h0003, "R5 hold mid burst");
    cyc(0, 0, 0, 1, 15'h0000, "R4 xor beat3");
    cyc(0, 0, 0, 1, 15'h0000, "R4 xor beat4");
    cyc(0, 0, 0, 1, 15'h0000, "R6 xor wrap");
    // Load coinciding with advance.
    cyc(0, 1, 0, 1, 15'h0011, "R7 load beats advance");
    cyc(0, 0, 0, 1, 15'h0000, "R4 xor from 01");
    // Mid-burst reload, switching order with the load.
    cyc(0, 1, 0, 0, 15'h4003, "R9 reload mid burst");
    cyc(0, 0, 0, 0, 15'h0000, "R9 linear from 11");
    cyc(0, 0, 0, 0, 15'h0000, "R3 linear 11 path");
    cyc(0, 0, 0, 0, 15'h0000, "R3 linear 11 path");
    cyc(0, 0, 0, 0, 15'h0000, "R6 linear wrap 11");
    // Interleaved from 11 full cycle.
    cyc(0, 1, 1, 1, 15'h3FFF, "R2 load 11");
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1, 15'h0000, "R4 R6 xor from 11");
    cyc(1, 0, 0, 1, 15'h0000, "R1 reset mid burst");
    cyc(0, 0, 1, 1, 15'h0000, "R5 hold after reset");
    cyc(0, 0, 1, 1, 15'h0000, "tail");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule